// File: doc/BRIEF.md
# Pedestrian Crossing Light Sequencer

This block drives the lamps at a signalled pedestrian crossing. It has two lamps that face pedestrians (red, green) and three that face vehicles (red, yellow, green). The lamps step through four fixed phases. Each phase is held for a programmable number of clock cycles, sixteen by default. The block is meant to run from a 1 Hz tick, so one cycle is one second and the dwell is sixteen seconds.

A push-button request, already synchronised and sampled on the clock, brings the walk phase back early. The request is taken only in a non-walk phase. The time left in the current phase is then cut to at most a second, smaller limit (eight cycles by default). When that time runs out the sequencer goes straight to the walk phase and skips the rest of the rotation. A press that lasts one cycle is held internally until the walk phase is reached. An asynchronous reset puts the sequencer in the walk phase and starts a full dwell.

Top module: `walk_crossing_ctrl`

## Requirements
- R1: While `rst` is high the lamps show the walk pattern: `pedGreen`=1, `carRed`=1, and `pedRed`, `carYellow`, `carGreen` all 0. This takes effect without waiting for a clock edge.
- R2: With no request, every phase is shown for exactly `DWELL_CYCLES` clock cycles. The walk phase after reset release is visible on the first `DWELL_CYCLES` rising edges and changes on the edge after that.
- R3: With no request, the phases run walk → prepare → go → stop → walk.
- R4: The lamp patterns, in bit order {pedRed, pedGreen, carRed, carYellow, carGreen}, are:
  - walk = 01100
  - prepare = 10110
  - go = 10001
  - stop = 10010

  Exactly one pedestrian lamp is lit in every phase.
- R5: A request sampled in a non-walk phase that has more than `CUT_CYCLES` cycles left brings the walk phase exactly `CUT_CYCLES` rising edges after the sampling edge.
- R6: A request held high for a single cycle is honoured in the same way as a held request.
- R7: A request sampled during the walk phase has no effect. The walk phase keeps its full dwell and is followed by prepare.
- R8: A walk phase that a request brought in is held for the full `DWELL_CYCLES` cycles.
- R9: A request sampled when fewer than `CUT_CYCLES` cycles remain does not move the moment of the phase change. Only the destination changes, to walk.
- R10: A request sampled on the final cycle of a non-walk phase makes that same edge go straight to walk.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase clock, one cycle per second in the intended use |
| rst | input | 1 | Asynchronous reset, active high; forces the walk phase |
| pedReq | input | 1 | Synchronous pedestrian request, active high |
| pedRed | output | 1 | Pedestrian red lamp enable |
| pedGreen | output | 1 | Pedestrian green lamp enable |
| carRed | output | 1 | Vehicle red lamp enable |
| carYellow | output | 1 | Vehicle yellow lamp enable |
| carGreen | output | 1 | Vehicle green lamp enable |

## Verification
The bench builds the block with its default values: a dwell of sixteen cycles and a cut limit of eight. A full rotation therefore takes only 64 cycles, so several rotations fit in a short run. With these values a request can land in each of three places: before the cut limit, inside the last eight cycles, and on the final cycle of a phase. Each case gives its own exact expected edge. A long run with sparse random presses then checks the lamps against a behavioural model on every cycle, through phases that were cut short and phases that were not.

// File: rtl/walk_pkg.sv
package walk_pkg;

  typedef enum logic [1:0] {
    PH_WALK = 2'd0,
    PH_PREP = 2'd1,
    PH_GO   = 2'd2,
    PH_STOP = 2'd3
  } phase_t;

  // strobes from the phase control to the dwell datapath
  typedef struct packed {
    logic reload;
    logic clamp;
  } dwell_ctl_t;

  typedef struct packed {
    logic pedRed;
    logic pedGreen;
    logic carRed;
    logic carYellow;
    logic carGreen;
  } lamp_t;

  function automatic phase_t nextInRotation(phase_t cur);
    unique case (cur)
      PH_WALK: nextInRotation = PH_PREP;
      PH_PREP: nextInRotation = PH_GO;
      PH_GO:   nextInRotation = PH_STOP;
      default: nextInRotation = PH_WALK;
    endcase
  endfunction

endpackage

// File: rtl/walk_dwell.sv
module walk_dwell
  import walk_pkg::*;
#(
  parameter int DWELL_CYCLES = 16,
  parameter int CUT_CYCLES   = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  dwell_ctl_t ctl,
  output logic       expired,
  output logic       pending
);

  localparam int W = (DWELL_CYCLES > 2) ? $clog2(DWELL_CYCLES) : 1;
  localparam logic [W-1:0] FULL_LEFT = W'(DWELL_CYCLES - 1);
  localparam logic [W-1:0] CUT_LEFT  = W'(CUT_CYCLES - 1);

  logic [W-1:0] cyclesLeft;
  logic         reqHeld;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cyclesLeft <= FULL_LEFT;
      reqHeld    <= 1'b0;
    end else if (ctl.reload) begin
      cyclesLeft <= FULL_LEFT;
      reqHeld    <= 1'b0;
    end else if (ctl.clamp) begin
      cyclesLeft <= (cyclesLeft > CUT_LEFT) ? CUT_LEFT : cyclesLeft - 1'b1;
      reqHeld    <= 1'b1;
    end else begin
      cyclesLeft <= cyclesLeft - 1'b1;
    end
  end

  assign expired = (cyclesLeft == '0);
  assign pending = reqHeld;

endmodule

// File: rtl/walk_phase.sv
module walk_phase
  import walk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pedReq,
  input  logic       expired,
  input  logic       pending,
  output dwell_ctl_t ctl,
  output phase_t     phase
);

  phase_t phaseQ, phaseD;
  logic   reqTaken;

  assign reqTaken = pedReq && (phaseQ != PH_WALK);

  always_comb begin
    phaseD     = phaseQ;
    ctl.reload = 1'b0;
    ctl.clamp  = 1'b0;
    if (expired) begin
      ctl.reload = 1'b1;
      phaseD     = (pending || reqTaken) ? PH_WALK : nextInRotation(phaseQ);
    end else if (reqTaken) begin
      ctl.clamp = 1'b1;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) phaseQ <= PH_WALK;
    else     phaseQ <= phaseD;
  end

  assign phase = phaseQ;

endmodule

// File: rtl/walk_lamps.sv
module walk_lamps
  import walk_pkg::*;
(
  input  phase_t phase,
  output lamp_t  lamps
);

  always_comb begin
    lamps = '0;
    unique case (phase)
      PH_WALK: begin lamps.pedGreen = 1'b1; lamps.carRed = 1'b1; end
      PH_PREP: begin lamps.pedRed = 1'b1; lamps.carRed = 1'b1; lamps.carYellow = 1'b1; end
      PH_GO:   begin lamps.pedRed = 1'b1; lamps.carGreen = 1'b1; end
      default: begin lamps.pedRed = 1'b1; lamps.carYellow = 1'b1; end
    endcase
  end

endmodule

// File: rtl/walk_crossing_ctrl.sv
module walk_crossing_ctrl
  import walk_pkg::*;
#(
  parameter int DWELL_CYCLES = 16,
  parameter int CUT_CYCLES   = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic pedReq,
  output logic pedRed,
  output logic pedGreen,
  output logic carRed,
  output logic carYellow,
  output logic carGreen
);

  dwell_ctl_t ctl;
  phase_t     phase;
  lamp_t      lamps;
  logic       expired;
  logic       pending;

  walk_phase u_phase (
    .clk     (clk),
    .rst     (rst),
    .pedReq  (pedReq),
    .expired (expired),
    .pending (pending),
    .ctl     (ctl),
    .phase   (phase)
  );

  walk_dwell #(
    .DWELL_CYCLES (DWELL_CYCLES),
    .CUT_CYCLES   (CUT_CYCLES)
  ) u_dwell (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .expired (expired),
    .pending (pending)
  );

  walk_lamps u_lamps (
    .phase (phase),
    .lamps (lamps)
  );

  assign pedRed    = lamps.pedRed;
  assign pedGreen  = lamps.pedGreen;
  assign carRed    = lamps.carRed;
  assign carYellow = lamps.carYellow;
  assign carGreen  = lamps.carGreen;

endmodule

// File: rtl/walk_crossing_check.sv
module walk_crossing_check #(
  parameter int DWELL_CYCLES = 16,
  parameter int CUT_CYCLES   = 8
) (
  input logic clk,
  input logic rst,
  input logic pedReq,
  input logic pedRed,
  input logic pedGreen,
  input logic carRed,
  input logic carYellow,
  input logic carGreen
);

  logic [4:0]  lampsNow, lampsPrev;
  int unsigned sameRun;
  int unsigned waitRun;
  logic        armed;

  assign lampsNow = {pedRed, pedGreen, carRed, carYellow, carGreen};

  // length of the current unchanged lamp run, in cycles
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      lampsPrev <= 5'b01100;
      sameRun   <= 0;
    end else begin
      lampsPrev <= lampsNow;
      if (lampsNow == lampsPrev) sameRun <= (sameRun < DWELL_CYCLES + 2) ? sameRun + 1 : sameRun;
      else                       sameRun <= 1;
    end
  end

  // cycles since a request taken outside the walk phase
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      armed   <= 1'b0;
      waitRun <= 0;
    end else if (pedGreen) begin
      armed   <= 1'b0;
      waitRun <= 0;
    end else if (armed || pedReq) begin
      armed   <= 1'b1;
      waitRun <= (waitRun < CUT_CYCLES + 2) ? waitRun + 1 : waitRun;
    end
  end

  AST_RESET_WALK: assert property (@(posedge clk)
    rst |-> (pedGreen && carRed && !pedRed && !carYellow && !carGreen)); // R1

  AST_DWELL_LIMIT: assert property (@(posedge clk) disable iff (rst)
    sameRun <= DWELL_CYCLES); // R2

  AST_WALK_TO_PREP: assert property (@(posedge clk) disable iff (rst)
    $fell(pedGreen) |-> (carRed && carYellow && !carGreen)); // R3

  AST_GO_FROM_PREP: assert property (@(posedge clk) disable iff (rst)
    $rose(carGreen) |-> $past(carRed && carYellow)); // R3

  AST_GO_LEAVES: assert property (@(posedge clk) disable iff (rst)
    $fell(carGreen) |-> (carYellow || pedGreen)); // R3

  AST_ONE_PED_LAMP: assert property (@(posedge clk) disable iff (rst)
    pedRed != pedGreen); // R4

  AST_WALK_SAFE: assert property (@(posedge clk) disable iff (rst)
    pedGreen |-> (carRed && !carYellow && !carGreen)); // R4

  AST_REQ_BOUND: assert property (@(posedge clk) disable iff (rst)
    (waitRun > CUT_CYCLES) |-> pedGreen); // R5

endmodule

bind walk_crossing_ctrl walk_crossing_check #(
  .DWELL_CYCLES (DWELL_CYCLES),
  .CUT_CYCLES   (CUT_CYCLES)
) u_check (
  .clk       (clk),
  .rst       (rst),
  .pedReq    (pedReq),
  .pedRed    (pedRed),
  .pedGreen  (pedGreen),
  .carRed    (carRed),
  .carYellow (carYellow),
  .carGreen  (carGreen)
);

// File: tb/walk_crossing_ctrl_bench.sv
module walk_crossing_ctrl_bench;

  localparam int DWELL = 16;
  localparam int CUT   = 8;
  localparam logic [4:0] P_WALK = 5'b01100;
  localparam logic [4:0] P_PREP = 5'b10110;
  localparam logic [4:0] P_GO   = 5'b10001;
  localparam logic [4:0] P_STOP = 5'b10010;

  logic clk = 1'b0;
  logic rst;
  logic pedReq = 1'b0;
  logic pedRed, pedGreen, carRed, carYellow, carGreen;
  logic [4:0] lampsNow;

  int checks = 0;
  int errors = 0;
  bit modelOn = 0;
  bit done = 0;

  always #4 clk = ~clk;

  walk_crossing_ctrl #(.DWELL_CYCLES(DWELL), .CUT_CYCLES(CUT)) u_walk_crossing_ctrl (
    .clk(clk), .rst(rst), .pedReq(pedReq),
    .pedRed(pedRed), .pedGreen(pedGreen), .carRed(carRed),
    .carYellow(carYellow), .carGreen(carGreen)
  );

  assign lampsNow = {pedRed, pedGreen, carRed, carYellow, carGreen};

  function automatic logic [4:0] patternOf(int ph);
    case (ph)
      1: patternOf = P_WALK;
      2: patternOf = P_PREP;
      3: patternOf = P_GO;
      default: patternOf = P_STOP;
    endcase
  endfunction

  task automatic check(input logic [4:0] got, input logic [4:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: lamps=%b expected=%b at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference: phase number 1..4, seconds left, held request
  int mPh, mLeft;
  bit mPend;
  always @(posedge clk or posedge rst) begin
    if (rst) begin
      mPh <= 1; mLeft <= DWELL - 1; mPend <= 0;
    end else if (mLeft == 0) begin
      mPh   <= (mPend || (pedReq && mPh != 1)) ? 1 : (mPh % 4) + 1;
      mLeft <= DWELL - 1;
      mPend <= 0;
    end else if (pedReq && mPh != 1) begin
      mLeft <= (mLeft > CUT - 1) ? CUT - 1 : mLeft - 1;
      mPend <= 1;
    end else begin
      mLeft <= mLeft - 1;
    end
  end

  always @(negedge clk) begin
    if (modelOn && !rst) check(lampsNow, patternOf(mPh), "R4 model");
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulseReq;
    pedReq = 1'b1;
    @(negedge clk);
    pedReq = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b0;
    #1 rst = 1'b1;
    #2;
    check(lampsNow, P_WALK, "R1 async reset");
    cycles(3);
    check(lampsNow, P_WALK, "R1 reset held");
    rst = 1'b0;
    modelOn = 1;

    // R2 R3: plain rotation
    cycles(DWELL - 1);
    check(lampsNow, P_WALK, "R2 walk last cycle");
    cycles(1);
    check(lampsNow, P_PREP, "R2 R3 walk->prep");
    cycles(DWELL - 1);
    check(lampsNow, P_PREP, "R2 prep last cycle");
    cycles(1);
    check(lampsNow, P_GO, "R3 prep->go");
    cycles(DWELL);
    check(lampsNow, P_STOP, "R3 go->stop");
    cycles(DWELL);
    check(lampsNow, P_WALK, "R3 stop->walk");

    // R7: request during walk ignored
    pulseReq();
    cycles(DWELL - 2);
    check(lampsNow, P_WALK, "R7 walk kept full dwell");
    cycles(1);
    check(lampsNow, P_PREP, "R7 walk->prep after ignored request");

    // R5 R6: single-cycle request early in prep
    cycles(3);
    pulseReq();
    cycles(CUT - 1);
    check(lampsNow, P_PREP, "R5 still prep before cut expires");
    cycles(1);
    check(lampsNow, P_WALK, "R5 R6 walk after cut");

    // R8: forced walk has full dwell
    cycles(DWELL - 1);
    check(lampsNow, P_WALK, "R8 forced walk last cycle");
    cycles(1);
    check(lampsNow, P_PREP, "R8 forced walk ends");

    // R9: late request does not move the change
    cycles(DWELL - 4);
    pulseReq();
    cycles(2);
    check(lampsNow, P_PREP, "R9 prep keeps remaining time");
    cycles(1);
    check(lampsNow, P_WALK, "R9 change at original edge, to walk");

    // R10: request on final cycle of go
    cycles(DWELL);
    check(lampsNow, P_PREP, "R10 setup prep");
    cycles(DWELL);
    check(lampsNow, P_GO, "R10 setup go");
    cycles(DWELL - 1);
    pulseReq();
    check(lampsNow, P_WALK, "R10 go straight to walk");

    // random sparse presses, compared every cycle with the model (R4 R5 R6)
    for (int i = 0; i < 1200; i++) begin
      pedReq = ($urandom_range(0, 24) == 0);
      @(negedge clk);
    end
    pedReq = 1'b0;
    cycles(4);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule